// File: doc/BRIEF.md
# Partition Dead-Time Monitor

This block keeps the monitoring counters that a central trigger controller needs for luminosity and efficiency bookkeeping. It serves a number of readout partitions, each with its own set of counters. On every bunch-crossing clock it samples, per partition, whether the accept signal is being held off and whether a trigger was actually sent. It also samples three flags shared by all partitions: whether the crossing is a filled one according to the beam structure, whether a raw accept was requested, and whether an orbit begins.

Each partition counts held-off crossings over all crossings and over filled crossings only. It also counts requests that were lost because they arrived while held off, and triggers it actually distributed. One shared orbit counter runs beside them. Two gate outputs go to external luminosity counters. The live gate is high when no partition holds the accept off. The run gate is opened by a start pulse and closed by a stop pulse. Software reads any counter through a small registered read port, and a single clear input zeroes all counters at once.

Top module: `partition_deadtime_monitor`

## Requirements
- R1: Synchronous active-high reset zeroes every counter and the read data, drives run_gate low and drives live_gate high.
- R2: For each partition p, the all-crossing dead counter (read select 0) increases by one at each clock edge where bx_inhibit[p] is high.
- R3: For each partition p, the active dead counter (read select 1) increases by one at each edge where bx_inhibit[p] and bx_active are both high.
- R4: For each partition p, the lost-trigger counter (read select 2) increases by one at each edge where bx_inhibit[p] and l1a_request are both high.
- R5: For each partition p, the distributed-trigger counter (read select 3) increases by one at each edge where l1a_sent[p] is high.
- R6: The orbit counter (read select 4, the same for every rd_part) increases by one at each edge where orbit_mark is high and wraps to zero after 2^ORBIT_W-1.
- R7: The four partition counters hold at 2^CNT_W-1 rather than wrap.
- R8: A high clr zeroes all counters, including the orbit counter, at the next edge and overrides any increment in that cycle.
- R9: rd_data, one edge after rd_sel and rd_part are presented, shows the selected counter as it stood before that edge, zero-extended. Selects 5 to 7 read zero. Reading never changes a counter.
- R10: live_gate, one edge after a crossing, is the inverse of the OR of bx_inhibit over all partitions for that crossing.
- R11: run_gate goes high one edge after run_start and low one edge after run_stop. Stop wins when both are high, and the gate holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clear all counters |
| bx_active | input | 1 | Crossing is filled according to beam structure |
| l1a_request | input | 1 | Raw accept requested this crossing |
| orbit_mark | input | 1 | Start of an orbit |
| bx_inhibit | input | NUM_PART | Per-partition accept hold-off |
| l1a_sent | input | NUM_PART | Per-partition trigger actually distributed |
| run_start | input | 1 | Opens the run gate |
| run_stop | input | 1 | Closes the run gate |
| rd_part | input | PART_W | Partition to read |
| rd_sel | input | 3 | Counter to read (0 to 4, see requirements) |
| rd_data | output | RD_W | Registered read value |
| live_gate | output | 1 | Live-time gate for luminosity counting |
| run_gate | output | 1 | Running gate |

## Verification
Every result of this block is due exactly one edge after its stimulus. A crossing's flags move the counters at the edge that samples them. The gates follow at that same edge. A read request shows the pre-edge counter value after one edge, so a counter bumped at edge k is first visible in rd_data at edge k+1. The bench applies inputs at the falling edge and advances its model by one edge at a time. It compares rd_data and both gates at the next falling edge, which keeps each comparison aligned with that single register stage. Saturation and orbit wrap are exercised with narrow counter widths chosen as bench parameters.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    localparam int NUM_PART_CNT = 4;
    localparam int SEL_W        = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_DEAD_ALL = 3'd0,
        SEL_DEAD_ACT = 3'd1,
        SEL_LOST     = 3'd2,
        SEL_SENT     = 3'd3,
        SEL_ORBIT    = 3'd4
    } cnt_sel_e;

    typedef struct packed {
        logic sent;
        logic lost;
        logic dead_act;
        logic dead_all;
    } part_evt_t;

    function automatic part_evt_t make_events(input logic inhibit, input logic active,
                                              input logic request, input logic sent);
        part_evt_t ev;
        ev.dead_all = inhibit;
        ev.dead_act = inhibit & active;
        ev.lost     = inhibit & request;
        ev.sent     = sent;
        return ev;
    endfunction

endpackage

// File: rtl/dtm_sat_counter.sv
module dtm_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/dtm_partition.sv
module dtm_partition
    import dtm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   clr,
    input  logic                                   inhibit,
    input  logic                                   active,
    input  logic                                   request,
    input  logic                                   sent,
    output logic [NUM_PART_CNT-1:0][CNT_W-1:0]     counts
);
    part_evt_t                  ev;
    logic [NUM_PART_CNT-1:0]    ev_vec;

    always_comb begin
        ev = make_events(inhibit, active, request, sent);
        ev_vec = '0;
        ev_vec[SEL_DEAD_ALL[1:0]] = ev.dead_all;
        ev_vec[SEL_DEAD_ACT[1:0]] = ev.dead_act;
        ev_vec[SEL_LOST[1:0]]     = ev.lost;
        ev_vec[SEL_SENT[1:0]]     = ev.sent;
    end

    for (genvar k = 0; k < NUM_PART_CNT; k++) begin : g_cnt
        dtm_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr   (clr),
            .inc   (ev_vec[k]),
            .count (counts[k])
        );
    end
endmodule

// File: rtl/dtm_gates.sv
module dtm_gates (
    input  logic clk,
    input  logic rst,
    input  logic inhibit_any,
    input  logic run_start,
    input  logic run_stop,
    output logic live_gate,
    output logic run_gate
);
    always_ff @(posedge clk) begin
        if (rst) begin
            live_gate <= 1'b1;
            run_gate  <= 1'b0;
        end else begin
            live_gate <= ~inhibit_any;
            if (run_stop) begin
                run_gate <= 1'b0;
            end else if (run_start) begin
                run_gate <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/partition_deadtime_monitor.sv
module partition_deadtime_monitor
    import dtm_pkg::*;
#(
    parameter int NUM_PART = 8,
    parameter int CNT_W    = 32,
    parameter int ORBIT_W  = 32,
    localparam int PART_W  = (NUM_PART > 1) ? $clog2(NUM_PART) : 1,
    localparam int RD_W    = (CNT_W > ORBIT_W) ? CNT_W : ORBIT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                bx_active,
    input  logic                l1a_request,
    input  logic                orbit_mark,
    input  logic [NUM_PART-1:0] bx_inhibit,
    input  logic [NUM_PART-1:0] l1a_sent,
    input  logic                run_start,
    input  logic                run_stop,
    input  logic [PART_W-1:0]   rd_part,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [RD_W-1:0]     rd_data,
    output logic                live_gate,
    output logic                run_gate
);
    logic [NUM_PART-1:0][NUM_PART_CNT-1:0][CNT_W-1:0] cnt_all;
    logic [ORBIT_W-1:0]                               orbit_q;
    logic [RD_W-1:0]                                  rd_next;

    for (genvar p = 0; p < NUM_PART; p++) begin : g_part
        dtm_partition #(.CNT_W(CNT_W)) u_part (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr),
            .inhibit (bx_inhibit[p]),
            .active  (bx_active),
            .request (l1a_request),
            .sent    (l1a_sent[p]),
            .counts  (cnt_all[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            orbit_q <= '0;
        end else if (orbit_mark) begin
            orbit_q <= orbit_q + 1'b1;
        end
    end

    dtm_gates u_gates (
        .clk         (clk),
        .rst         (rst),
        .inhibit_any (|bx_inhibit),
        .run_start   (run_start),
        .run_stop    (run_stop),
        .live_gate   (live_gate),
        .run_gate    (run_gate)
    );

    always_comb begin
        rd_next = '0;
        case (cnt_sel_e'(rd_sel))
            SEL_DEAD_ALL, SEL_DEAD_ACT, SEL_LOST, SEL_SENT: begin
                if (int'(rd_part) < NUM_PART) begin
                    rd_next = RD_W'(cnt_all[rd_part][rd_sel[1:0]]);
                end
            end
            SEL_ORBIT: rd_next = RD_W'(orbit_q);
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_next;
        end
    end
endmodule

// File: rtl/dtm_checker.sv
module dtm_checker
    import dtm_pkg::*;
#(
    parameter int NUM_PART = 8,
    parameter int CNT_W    = 32,
    parameter int ORBIT_W  = 32
) (
    input logic                                             clk,
    input logic                                             rst,
    input logic                                             clr,
    input logic [NUM_PART-1:0]                              bx_inhibit,
    input logic                                             run_start,
    input logic                                             run_stop,
    input logic                                             live_gate,
    input logic                                             run_gate,
    input logic [ORBIT_W-1:0]                               orbit_q,
    input logic [NUM_PART-1:0][NUM_PART_CNT-1:0][CNT_W-1:0] cnt_all
);
    // R10
    live_gate_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (live_gate == !$past(|bx_inhibit)));

    // R11
    run_stop_chk: assert property (@(posedge clk) disable iff (rst)
        run_stop |=> !run_gate);

    // R11
    run_start_chk: assert property (@(posedge clk) disable iff (rst)
        (run_start && !run_stop) |=> run_gate);

    // R11
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_start && !run_stop) |=> $stable(run_gate));

    // R8
    orbit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (orbit_q == '0));

    for (genvar p = 0; p < NUM_PART; p++) begin : g_p
        for (genvar k = 0; k < NUM_PART_CNT; k++) begin : g_k
            // R8
            cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
                clr |=> (cnt_all[p][k] == '0));

            // R7
            cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
                !clr |=> ((cnt_all[p][k] >= $past(cnt_all[p][k])) &&
                          ((cnt_all[p][k] - $past(cnt_all[p][k])) <= CNT_W'(1))));
        end
    end
endmodule

bind partition_deadtime_monitor dtm_checker #(
    .NUM_PART (NUM_PART),
    .CNT_W    (CNT_W),
    .ORBIT_W  (ORBIT_W)
) u_dtm_chk (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .bx_inhibit (bx_inhibit),
    .run_start  (run_start),
    .run_stop   (run_stop),
    .live_gate  (live_gate),
    .run_gate   (run_gate),
    .orbit_q    (orbit_q),
    .cnt_all    (cnt_all)
);

// File: tb/tb_partition_deadtime_monitor.sv
module tb_partition_deadtime_monitor;
    localparam int NP    = 8;
    localparam int CW    = 6;
    localparam int OW    = 8;
    localparam int PW    = 3;
    localparam int RW    = 8;
    localparam longint CMAX = (64'd1 << CW) - 1;
    localparam longint OMOD = (64'd1 << OW);

    logic          clk = 1'b0;
    logic          rst, clr, bx_active, l1a_request, orbit_mark, run_start, run_stop;
    logic [NP-1:0] bx_inhibit, l1a_sent;
    logic [PW-1:0] rd_part;
    logic [2:0]    rd_sel;
    logic [RW-1:0] rd_data;
    logic          live_gate, run_gate;

    always #2.5 clk = ~clk;

    partition_deadtime_monitor #(.NUM_PART(NP), .CNT_W(CW), .ORBIT_W(OW)) dut (
        .clk(clk), .rst(rst), .clr(clr), .bx_active(bx_active),
        .l1a_request(l1a_request), .orbit_mark(orbit_mark),
        .bx_inhibit(bx_inhibit), .l1a_sent(l1a_sent),
        .run_start(run_start), .run_stop(run_stop),
        .rd_part(rd_part), .rd_sel(rd_sel), .rd_data(rd_data),
        .live_gate(live_gate), .run_gate(run_gate)
    );

    int     checks = 0;
    int     errors = 0;
    longint m_cnt [NP][4];
    longint m_orbit;
    longint m_rd;
    bit     m_live, m_run;
    int     last_sel;

    function automatic longint read_model(input int sel, input int part);
        if (sel <= 3) return m_cnt[part][sel];
        if (sel == 4) return m_orbit;
        return 0;
    endfunction

    function automatic string sel_tag(input int sel);
        case (sel)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit r, input bit cl, input logic [NP-1:0] inh, input bit act,
                        input bit req, input logic [NP-1:0] snt, input bit orb,
                        input bit st, input bit sp, input int sel, input int part,
                        input string tag);
        string t;
        rst = r; clr = cl; bx_inhibit = inh; bx_active = act; l1a_request = req;
        l1a_sent = snt; orbit_mark = orb; run_start = st; run_stop = sp;
        rd_sel = 3'(sel); rd_part = PW'(part);
        if (r) begin
            m_rd = 0; m_live = 1; m_run = 0; m_orbit = 0;
            foreach (m_cnt[p, k]) m_cnt[p][k] = 0;
        end else begin
            m_rd = read_model(sel, part);
            m_live = !(|inh);
            if (sp) m_run = 0; else if (st) m_run = 1;
            if (cl) begin
                m_orbit = 0;
                foreach (m_cnt[p, k]) m_cnt[p][k] = 0;
            end else begin
                if (orb) m_orbit = (m_orbit + 1) % OMOD;
                for (int p = 0; p < NP; p++) begin
                    if (inh[p] && m_cnt[p][0] < CMAX) m_cnt[p][0]++;
                    if (inh[p] && act && m_cnt[p][1] < CMAX) m_cnt[p][1]++;
                    if (inh[p] && req && m_cnt[p][2] < CMAX) m_cnt[p][2]++;
                    if (snt[p] && m_cnt[p][3] < CMAX) m_cnt[p][3]++;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        if (tag != "") t = tag;
        else if (sel <= 3 && m_rd == CMAX) t = "R7";
        else t = sel_tag(sel);
        check({t, " rd_data"}, longint'(rd_data), m_rd);
        check(r ? "R1 live_gate" : "R10 live_gate", longint'(live_gate), longint'(m_live));
        check(r ? "R1 run_gate" : "R11 run_gate", longint'(run_gate), longint'(m_run));
    endtask

    task automatic idle_read(input int sel, input int part, input string tag);
        step(0, 0, '0, 0, 0, '0, 0, 0, 0, sel, part, tag);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R1: reset state, then every counter reads zero
        repeat (3) step(1, 0, '0, 0, 0, '0, 0, 0, 0, 0, 0, "R1");
        for (int s = 0; s < 5; s++)
            for (int p = 0; p < NP; p++) idle_read(s, p, "R1");

        // R2 R3 R4 R5 R6 R10 R11: mixed random traffic with rotating reads
        for (int i = 0; i < 600; i++) begin
            step(0, 0, NP'($urandom), 1'($urandom), 1'($urandom), NP'($urandom),
                 ($urandom % 8) == 0, ($urandom % 16) == 0, ($urandom % 16) == 0,
                 int'($urandom % 8), int'($urandom % NP), "");
        end

        // R7: sustained events drive every partition counter to its ceiling
        for (int i = 0; i < 80; i++)
            step(0, 0, '1, 1, 1, '1, 0, 0, 0, i % 4, (i / 4) % NP, "");
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < NP; p++) idle_read(s, p, "R7");

        // R6: orbit counter wraps
        for (int i = 0; i < 300; i++) step(0, 0, '0, 0, 0, '0, 1, 0, 0, 4, i % NP, "R6");

        // R8: clear beats simultaneous events
        step(0, 1, '1, 1, 1, '1, 1, 0, 0, 0, 0, "R8");
        for (int s = 0; s < 5; s++)
            for (int p = 0; p < NP; p++) idle_read(s, p, "R8");

        // R9: repeated reads leave values unchanged; unused selects give zero
        for (int i = 0; i < 10; i++) step(0, 0, 8'h05, 1, 0, 8'h02, 0, 0, 0, 7, 0, "R9");
        for (int i = 0; i < 6; i++) idle_read(0, 2, "R9");
        for (int i = 0; i < 6; i++) idle_read(5 + i % 3, i, "R9");

        // R11: start, hold, both together, start again, stop
        step(0, 0, '0, 0, 0, '0, 0, 1, 0, 3, 1, "R11");
        idle_read(3, 1, "R11");
        step(0, 0, '0, 0, 0, '0, 0, 1, 1, 3, 1, "R11");
        idle_read(3, 1, "R11");
        step(0, 0, '0, 0, 0, '0, 0, 1, 0, 3, 1, "R11");
        step(0, 0, '0, 0, 0, '0, 0, 0, 1, 3, 1, "R11");
        idle_read(3, 1, "R11");

        // R10: single-partition inhibit closes live gate
        step(0, 0, 8'h80, 0, 0, '0, 0, 0, 0, 0, 7, "R10");
        idle_read(0, 7, "R10");

        finish_run();
    end
endmodule